// File: doc/BRIEF.md
# Timed Wash Cycle Controller

This block runs the timed wash of a washing machine. After a start pulse it loads a wash time in minutes from two BCD preset digits. It then drives the motor through a repeating one-minute agitation pattern: forward, a rest, reverse, and a second rest. While the pattern runs it counts the remaining minutes down on two BCD digits. When the last second of the wash has passed, the motor stops and a buzzer output turns on. The buzzer stays on until a new valid start or a reset.

All timing advances only on a one-second tick enable. An external divider supplies that tick, and a testbench can drive it at any rate. The remaining-time digits and the three phase LEDs feed display logic that sits outside this block. That logic handles segment decoding and digit scanning, and it also debounces the keys.

Top module: `wash_ctrl`

## Requirements
- R1: A synchronous reset puts the block in idle. In idle every output is low: both motor commands, all three LEDs, the buzzer, and both remaining-time digits (00).
- R2: In idle or finished, a start pulse with a nonzero preset is accepted. One clock later the remaining-time digits equal the preset, and the forward phase runs from its first second.
- R3: While running, the phases come in this fixed order: forward for 20 ticks, rest for 10, reverse for 20, rest for 10. The order then repeats, so each pass lasts exactly 60 ticks.
- R4: motor_fwd is high only in the forward phase, and motor_rev only in the reverse phase. The two are never high together. Both are low during rests, in idle and when finished.
- R5: The LEDs are led_fwd, led_rev and led_pause. While running, exactly the one that matches the current phase is lit. When idle or finished, none is lit.
- R6: Every 60 ticks of running, the remaining minutes drop by one. When the units digit is 0, it becomes 9 and the tens digit drops by one (10 becomes 09).
- R7: On the tick that ends the final minute, the block moves to finished. The display shows 00, the motor stops and the buzzer turns on. The buzzer stays on until a valid start or a reset.
- R8: A start pulse with preset 00 has no effect, in idle or in finished.
- R9: A start pulse during a running wash has no effect. The digits, the phase and the position within the phase all continue unchanged.
- R10: In any cycle without a tick, no timing state advances and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-second enable, one clock wide |
| start | input | 1 | Start request, one clock wide |
| preset_tens | input | 4 | Preset minutes, BCD tens digit |
| preset_units | input | 4 | Preset minutes, BCD units digit |
| motor_fwd | output | 1 | Motor forward command |
| motor_rev | output | 1 | Motor reverse command |
| led_fwd | output | 1 | Forward phase indicator |
| led_rev | output | 1 | Reverse phase indicator |
| led_pause | output | 1 | Rest phase indicator |
| remain_tens | output | 4 | Remaining minutes, BCD tens digit |
| remain_units | output | 4 | Remaining minutes, BCD units digit |
| buzzer | output | 1 | End-of-wash alarm enable |

## Verification
A two-minute wash is stepped through a vector table that stops just before and just after every phase boundary and minute boundary. This separates an off-by-one phase length from a correct one, and it shows a minute that drops early or late. A ten-minute preset tests the tens borrow, which a single-digit run never reaches. A start during the run, mid-phase, shows whether the sequencer restarts or keeps going. Zero presets, starts from the finished state, tick-free idle stretches and resets in the running and finished states cover the acceptance and hold rules.

// File: rtl/wash_pkg.sv
package wash_pkg;

    localparam int FWD_SECS_DEF   = 20;
    localparam int REST_SECS_DEF  = 10;
    localparam int REV_SECS_DEF   = 20;
    localparam int SECS_PER_MIN   = 60;
    localparam int BCD_W          = 4;

    typedef enum logic [1:0] {
        PH_FWD    = 2'd0,
        PH_REST_A = 2'd1,
        PH_REV    = 2'd2,
        PH_REST_B = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_e;

    typedef struct packed {
        logic [BCD_W-1:0] tens;
        logic [BCD_W-1:0] units;
    } bcd2_t;

    function automatic bcd2_t bcd2_dec(input bcd2_t v);
        bcd2_t r;
        if (v.units == '0) begin
            r.units = BCD_W'(9);
            r.tens  = v.tens - BCD_W'(1);
        end else begin
            r.units = v.units - BCD_W'(1);
            r.tens  = v.tens;
        end
        return r;
    endfunction

    function automatic logic bcd2_is_one(input bcd2_t v);
        return (v.tens == '0) && (v.units == BCD_W'(1));
    endfunction

endpackage

// File: rtl/wash_phase_seq.sv
module wash_phase_seq
    import wash_pkg::*;
#(
    parameter int FWD_SECS  = FWD_SECS_DEF,
    parameter int REST_SECS = REST_SECS_DEF,
    parameter int REV_SECS  = REV_SECS_DEF
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    input  logic   advance,
    output phase_e phase
);
    localparam int MOTOR_MAX = (FWD_SECS > REV_SECS) ? FWD_SECS : REV_SECS;
    localparam int LEN_MAX   = (MOTOR_MAX > REST_SECS) ? MOTOR_MAX : REST_SECS;
    localparam int CW        = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;

    logic [CW-1:0] sec_in_phase;
    logic [CW-1:0] last_sec;

    always_comb begin
        case (phase)
            PH_FWD:  last_sec = CW'(FWD_SECS - 1);
            PH_REV:  last_sec = CW'(REV_SECS - 1);
            default: last_sec = CW'(REST_SECS - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase        <= PH_FWD;
            sec_in_phase <= '0;
        end else if (advance) begin
            if (sec_in_phase == last_sec) begin
                sec_in_phase <= '0;
                phase        <= phase_e'(phase + 2'd1);
            end else begin
                sec_in_phase <= sec_in_phase + CW'(1);
            end
        end
    end

endmodule

// File: rtl/wash_bcd_timer.sv
module wash_bcd_timer
    import wash_pkg::*;
#(
    parameter int SECS_MIN = SECS_PER_MIN
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  bcd2_t preset,
    input  logic  advance,
    output bcd2_t remain,
    output logic  expire
);
    localparam int SW = $clog2(SECS_MIN);
    localparam logic [SW-1:0] SEC_LAST = SW'(SECS_MIN - 1);

    logic [SW-1:0] sec_cnt;
    logic          min_wrap;

    assign min_wrap = advance && (sec_cnt == SEC_LAST);
    assign expire   = min_wrap && bcd2_is_one(remain);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain  <= '0;
            sec_cnt <= '0;
        end else if (load) begin
            remain  <= preset;
            sec_cnt <= '0;
        end else if (advance) begin
            if (min_wrap) begin
                sec_cnt <= '0;
                remain  <= bcd2_dec(remain);
            end else begin
                sec_cnt <= sec_cnt + SW'(1);
            end
        end
    end

endmodule

// File: rtl/wash_ctrl.sv
module wash_ctrl
    import wash_pkg::*;
#(
    parameter int FWD_SECS  = FWD_SECS_DEF,
    parameter int REST_SECS = REST_SECS_DEF,
    parameter int REV_SECS  = REV_SECS_DEF,
    parameter int SECS_MIN  = SECS_PER_MIN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_1s,
    input  logic             start,
    input  logic [BCD_W-1:0] preset_tens,
    input  logic [BCD_W-1:0] preset_units,
    output logic             motor_fwd,
    output logic             motor_rev,
    output logic             led_fwd,
    output logic             led_rev,
    output logic             led_pause,
    output logic [BCD_W-1:0] remain_tens,
    output logic [BCD_W-1:0] remain_units,
    output logic             buzzer
);
    run_e   state;
    phase_e phase;
    bcd2_t  preset;
    bcd2_t  remain;
    logic   start_ok;
    logic   advance;
    logic   expire;
    logic   running;

    assign preset   = '{tens: preset_tens, units: preset_units};
    assign running  = (state == ST_RUN);
    assign start_ok = start && (preset != '0) && !running;
    assign advance  = tick_1s && running;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else if (start_ok) begin
            state <= ST_RUN;
        end else if (running && expire) begin
            state <= ST_DONE;
        end
    end

    wash_phase_seq #(
        .FWD_SECS (FWD_SECS),
        .REST_SECS(REST_SECS),
        .REV_SECS (REV_SECS)
    ) i_seq (
        .clk    (clk),
        .rst    (rst),
        .restart(start_ok),
        .advance(advance),
        .phase  (phase)
    );

    wash_bcd_timer #(
        .SECS_MIN(SECS_MIN)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (start_ok),
        .preset (preset),
        .advance(advance),
        .remain (remain),
        .expire (expire)
    );

    assign motor_fwd    = running && (phase == PH_FWD);
    assign motor_rev    = running && (phase == PH_REV);
    assign led_fwd      = motor_fwd;
    assign led_rev      = motor_rev;
    assign led_pause    = running && ((phase == PH_REST_A) || (phase == PH_REST_B));
    assign remain_tens  = remain.tens;
    assign remain_units = remain.units;
    assign buzzer       = (state == ST_DONE);

endmodule

// File: rtl/wash_ctrl_chk.sv
module wash_ctrl_chk
    import wash_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick_1s,
    input logic             start,
    input logic [BCD_W-1:0] preset_tens,
    input logic [BCD_W-1:0] preset_units,
    input logic             motor_fwd,
    input logic             motor_rev,
    input logic             led_fwd,
    input logic             led_rev,
    input logic             led_pause,
    input logic [BCD_W-1:0] remain_tens,
    input logic [BCD_W-1:0] remain_units,
    input logic             buzzer
);
    logic busy;
    logic preset_nz;
    assign busy      = led_fwd || led_rev || led_pause;
    assign preset_nz = (preset_tens != '0) || (preset_units != '0);

    p_motor_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(motor_fwd && motor_rev));

    p_led_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0({led_fwd, led_rev, led_pause}));

    p_start_loads_r2: assert property (@(posedge clk) disable iff (rst)
        (start && preset_nz && !busy) |=>
        (motor_fwd && remain_tens == $past(preset_tens) && remain_units == $past(preset_units)));

    p_zero_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (start && !preset_nz && !busy) |=> !busy && $stable(buzzer));

    p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start && !tick_1s) |=>
        ($stable(remain_tens) && $stable(remain_units) && $stable({led_fwd, led_rev, led_pause})));

    p_buzz_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (buzzer && !(start && preset_nz)) |=> buzzer);

    p_buzz_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        buzzer |-> (!busy && !motor_fwd && !motor_rev && remain_tens == '0 && remain_units == '0));

    p_no_tick_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (!tick_1s && !start) |=>
        ($stable(remain_tens) && $stable(remain_units) && $stable({led_fwd, led_rev, led_pause, buzzer})));

endmodule

bind wash_ctrl wash_ctrl_chk i_chk (.*);

// File: tb/test_wash_ctrl.sv
module test_wash_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1s = 1'b0;
    logic       start = 1'b0;
    logic [3:0] preset_tens = 4'd0;
    logic [3:0] preset_units = 4'd0;
    logic       motor_fwd, motor_rev, led_fwd, led_rev, led_pause, buzzer;
    logic [3:0] remain_tens, remain_units;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    wash_ctrl i_wash_ctrl (
        .clk(clk), .rst(rst), .tick_1s(tick_1s), .start(start),
        .preset_tens(preset_tens), .preset_units(preset_units),
        .motor_fwd(motor_fwd), .motor_rev(motor_rev),
        .led_fwd(led_fwd), .led_rev(led_rev), .led_pause(led_pause),
        .remain_tens(remain_tens), .remain_units(remain_units),
        .buzzer(buzzer)
    );

    // leds = {fwd, rev, pause}; ticks = ticks applied before the check
    typedef struct packed {
        logic [7:0] ticks;
        logic [2:0] leds;
        logic [3:0] tens;
        logic [3:0] units;
        logic       buzz;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{8'd0,  3'b100, 4'd0, 4'd2, 1'b0},
        '{8'd19, 3'b100, 4'd0, 4'd2, 1'b0},
        '{8'd1,  3'b001, 4'd0, 4'd2, 1'b0},
        '{8'd9,  3'b001, 4'd0, 4'd2, 1'b0},
        '{8'd1,  3'b010, 4'd0, 4'd2, 1'b0},
        '{8'd19, 3'b010, 4'd0, 4'd2, 1'b0},
        '{8'd1,  3'b001, 4'd0, 4'd2, 1'b0},
        '{8'd9,  3'b001, 4'd0, 4'd2, 1'b0},
        '{8'd1,  3'b100, 4'd0, 4'd1, 1'b0},
        '{8'd59, 3'b001, 4'd0, 4'd1, 1'b0},
        '{8'd1,  3'b000, 4'd0, 4'd0, 1'b1}
    };

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick_1s = 1'b1;
            @(negedge clk) tick_1s = 1'b0;
        end
    endtask

    task automatic pulse_start(input logic [3:0] t, input logic [3:0] u);
        @(negedge clk);
        preset_tens = t;
        preset_units = u;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // actual/expected packed as {motor_fwd, motor_rev, leds[2:0], tens, units, buzzer}
    task automatic check_out(input string req, input logic [2:0] leds,
                             input logic [3:0] t, input logic [3:0] u, input logic bz);
        logic [15:0] act, exp;
        act = {motor_fwd, motor_rev, led_fwd, led_rev, led_pause, remain_tens, remain_units, buzzer};
        exp = {leds[2], leds[1], leds, t, u, bz};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_cycles(3);
        rst = 1'b0;
        idle_cycles(1);
        check_out("R1 reset state", 3'b000, 4'd0, 4'd0, 1'b0);

        do_ticks(5);
        check_out("R10 ticks in idle", 3'b000, 4'd0, 4'd0, 1'b0);

        pulse_start(4'd0, 4'd0);
        check_out("R8 zero preset in idle", 3'b000, 4'd0, 4'd0, 1'b0);

        // Two-minute wash walked through the phase and minute boundaries
        pulse_start(4'd0, 4'd2);
        for (int k = 0; k < NV; k++) begin
            do_ticks(int'(VECS[k].ticks));
            check_out($sformatf("R2 R3 R4 R5 R6 R7 vector %0d", k),
                      VECS[k].leds, VECS[k].tens, VECS[k].units, VECS[k].buzz);
        end

        idle_cycles(10);
        do_ticks(3);
        check_out("R7 buzzer held", 3'b000, 4'd0, 4'd0, 1'b1);

        pulse_start(4'd0, 4'd0);
        check_out("R8 zero preset in finished", 3'b000, 4'd0, 4'd0, 1'b1);

        pulse_start(4'd1, 4'd0);
        check_out("R2 load 10", 3'b100, 4'd1, 4'd0, 1'b0);
        do_ticks(60);
        check_out("R6 borrow 10 to 09", 3'b100, 4'd0, 4'd9, 1'b0);
        do_ticks(5);
        pulse_start(4'd0, 4'd5);
        check_out("R9 start while running", 3'b100, 4'd0, 4'd9, 1'b0);
        do_ticks(15);
        check_out("R9 position kept", 3'b001, 4'd0, 4'd9, 1'b0);
        idle_cycles(7);
        check_out("R10 no tick hold", 3'b001, 4'd0, 4'd9, 1'b0);
        do_ticks(10);
        check_out("R3 R4 reverse after rest", 3'b010, 4'd0, 4'd9, 1'b0);

        @(negedge clk) rst = 1'b1;
        idle_cycles(2);
        rst = 1'b0;
        idle_cycles(1);
        check_out("R1 reset while running", 3'b000, 4'd0, 4'd0, 1'b0);

        pulse_start(4'd0, 4'd1);
        do_ticks(59);
        check_out("R7 last second", 3'b001, 4'd0, 4'd1, 1'b0);
        do_ticks(1);
        check_out("R7 finish one minute", 3'b000, 4'd0, 4'd0, 1'b1);
        pulse_start(4'd0, 4'd1);
        check_out("R7 restart clears buzzer", 3'b100, 4'd0, 4'd1, 1'b0);
        do_ticks(60);
        check_out("R7 finish again", 3'b000, 4'd0, 4'd0, 1'b1);

        @(negedge clk) rst = 1'b1;
        idle_cycles(1);
        rst = 1'b0;
        idle_cycles(1);
        check_out("R1 reset while finished", 3'b000, 4'd0, 4'd0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule